// File: doc/BRIEF.md
# Shared Memory Swizzle Bank Mapper

This block takes a linear element address into a banked on-chip memory, applies an XOR-based permutation to it, and reports where the permuted element lands. The memory it models has 32 banks, each one 4 bytes wide. The outputs are the permuted element address, the bank index (0 to 31) and the bank line. The permutation takes a group of higher address bits and XORs it into a lower group. The lowest bits of the address are never touched, so a 16-byte run of elements stays contiguous. Two inputs set the size of the permutation: the element width (8, 16 or 32 bits) and the swizzle mode (none, 32-byte, 64-byte or 128-byte).

The unit is pipelined over two register stages. It accepts one address in every cycle and has no stall input. Each result is tagged with a valid bit. An element-width code that the block does not support produces a zero result with an error flag set. Storing the data and arbitrating between conflicting accesses are left to other logic.

Top module: `swz_bank_mapper`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` is 0.
- R2: An input presented with `in_valid`=1 at a clock edge gives its result, with `out_valid`=1, after the second edge that follows. Inputs on consecutive cycles give results on consecutive cycles. A cycle with `in_valid`=0 gives `out_valid`=0 two edges later.
- R3: The element-width code sets how many low bits K of the address are kept: code 0 (8-bit) gives K=4, code 1 (16-bit) gives K=3, code 2 (32-bit) gives K=2. Address bits below K pass to `out_addr` unchanged.
- R4: Mode code 1 (32B) sets F=1, code 2 (64B) sets F=2 and code 3 (128B) sets F=3. With x = addr >> K, bits [3, 3+F) of x are XORed into bits [0, F) of x. All other bits are unchanged.
- R5: Mode code 0 (none) leaves the address unchanged (F=0).
- R6: With E bytes per element (1, 2 or 4), the bank word is floor(out_addr·E/4). `out_bank` is the bank word mod 32 and `out_line` is the bank word divided by 32.
- R7: Width code 3 sets `out_err`=1 and forces `out_addr`, `out_bank` and `out_line` to 0. The supported codes give `out_err`=0.
- R8: With 16-bit elements in 128B mode, reading down column 0 of an 8-row tile addressed 64·i gives addresses 72·i and banks 4·i, which are eight distinct banks.
- R9: With 16-bit elements and mode none, the same column puts every row in bank 0, on line i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input address is present |
| in_addr | input | 20 | Linear element address |
| in_width | input | 2 | Element width code: 0=8b, 1=16b, 2=32b, 3=unsupported |
| in_mode | input | 2 | Swizzle mode: 0=none, 1=32B, 2=64B, 3=128B |
| out_valid | output | 1 | Result is present |
| out_addr | output | 20 | Permuted element address |
| out_bank | output | 5 | Bank index |
| out_line | output | 15 | Bank line |
| out_err | output | 1 | Unsupported width code |

## Verification
A table of vectors covers every pairing of width and mode that changes the folded field, including an all-ones address and an address with an empty fold field. These separate a wrong keep count from a wrong fold width, and a wrong fold width from a wrong byte scaling in the bank split. A streamed column walk, first with the swizzle and then without it, shows that the permutation spreads rows over distinct banks where the plain layout puts them all in one. It also shows that back-to-back inputs keep their order and their two-cycle latency. An unsupported width code placed between good vectors shows that the error result is zero and does not carry over into the next vector.

// File: rtl/swz_pkg.sv
package swz_pkg;
    localparam int ADDR_W     = 20;
    localparam int NUM_BANKS  = 32;
    localparam int BANK_W     = $clog2(NUM_BANKS);
    localparam int WORD_BYTES = 4;
    localparam int FOLD_SHIFT = 3;
    localparam int RUN_BITS   = 128;

    typedef enum logic [1:0] {
        EW_8   = 2'd0,
        EW_16  = 2'd1,
        EW_32  = 2'd2,
        EW_BAD = 2'd3
    } elem_w_e;

    typedef enum logic [1:0] {
        SWZ_NONE = 2'd0,
        SWZ_32B  = 2'd1,
        SWZ_64B  = 2'd2,
        SWZ_128B = 2'd3
    } swz_mode_e;

    typedef struct packed {
        logic [2:0] keep;
        logic [1:0] fold;
        logic [1:0] byte_log;
        logic       bad;
    } swz_cfg_t;

    function automatic int elem_bits(elem_w_e w);
        case (w)
            EW_8:    return 8;
            EW_16:   return 16;
            EW_32:   return 32;
            default: return RUN_BITS;
        endcase
    endfunction

    function automatic logic [2:0] keep_of(elem_w_e w);
        int ratio;
        int len;
        ratio = RUN_BITS / elem_bits(w);
        len   = 0;
        for (int i = 0; i < 8; i++) begin
            if ((ratio >> i) != 0) len = i + 1;
        end
        return 3'(len - 1);
    endfunction

    function automatic logic [1:0] byte_log_of(elem_w_e w);
        case (w)
            EW_16:   return 2'd1;
            EW_32:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [1:0] fold_of(swz_mode_e m);
        case (m)
            SWZ_32B:  return 2'd1;
            SWZ_64B:  return 2'd2;
            SWZ_128B: return 2'd3;
            default:  return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/swz_cfg_decode.sv
module swz_cfg_decode
    import swz_pkg::*;
(
    input  logic [1:0] width_code,
    input  logic [1:0] mode_code,
    output swz_cfg_t   cfg
);
    elem_w_e   w;
    swz_mode_e m;

    always_comb begin
        w            = elem_w_e'(width_code);
        m            = swz_mode_e'(mode_code);
        cfg.keep     = keep_of(w);
        cfg.byte_log = byte_log_of(w);
        cfg.fold     = fold_of(m);
        cfg.bad      = (w == EW_BAD);
    end
endmodule

// File: rtl/swz_permute.sv
module swz_permute #(
    parameter int AW    = 20,
    parameter int SHIFT = 3
) (
    input  logic [AW-1:0] addr_in,
    input  logic [2:0]    keep,
    input  logic [1:0]    fold,
    output logic [AW-1:0] addr_out
);
    logic [AW-1:0] x;
    logic [AW-1:0] fmask;
    logic [AW-1:0] lmask;
    logic [AW-1:0] fx;

    always_comb begin
        x        = addr_in >> keep;
        fmask    = (AW'(1) << fold) - AW'(1);
        lmask    = (AW'(1) << keep) - AW'(1);
        fx       = x ^ ((x >> SHIFT) & fmask);
        addr_out = (fx << keep) | (addr_in & lmask);
    end
endmodule

// File: rtl/swz_bank_split.sv
module swz_bank_split #(
    parameter int AW         = 20,
    parameter int NUM_BANKS  = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0]                     addr,
    input  logic [1:0]                        byte_log,
    output logic [$clog2(NUM_BANKS)-1:0]      bank,
    output logic [AW-$clog2(NUM_BANKS)-1:0]   line
);
    localparam int BW     = $clog2(NUM_BANKS);
    localparam int WB_LOG = $clog2(WORD_BYTES);
    localparam int WW     = AW + 2;

    logic [WW-1:0] byte_addr;
    logic [WW-1:0] word;

    always_comb begin
        byte_addr = WW'(addr) << byte_log;
        word      = byte_addr >> WB_LOG;
        bank      = word[BW-1:0];
        line      = (AW-BW)'(word >> BW);
    end
endmodule

// File: rtl/swz_bank_mapper.sv
module swz_bank_mapper
    import swz_pkg::*;
#(
    parameter int AW = swz_pkg::ADDR_W,
    parameter int NB = swz_pkg::NUM_BANKS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [AW-1:0]               in_addr,
    input  logic [1:0]                  in_width,
    input  logic [1:0]                  in_mode,
    output logic                        out_valid,
    output logic [AW-1:0]               out_addr,
    output logic [$clog2(NB)-1:0]       out_bank,
    output logic [AW-$clog2(NB)-1:0]    out_line,
    output logic                        out_err
);
    localparam int BW = $clog2(NB);
    localparam int LW = AW - BW;

    swz_cfg_t      cfg;
    logic [AW-1:0] perm_addr;

    logic          s1_valid;
    logic [AW-1:0] s1_addr;
    logic [1:0]    s1_blog;
    logic          s1_bad;

    logic [BW-1:0] sp_bank;
    logic [LW-1:0] sp_line;

    swz_cfg_decode u_dec (
        .width_code (in_width),
        .mode_code  (in_mode),
        .cfg        (cfg)
    );

    swz_permute #(.AW(AW), .SHIFT(FOLD_SHIFT)) u_perm (
        .addr_in  (in_addr),
        .keep     (cfg.keep),
        .fold     (cfg.fold),
        .addr_out (perm_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_addr  <= '0;
            s1_blog  <= '0;
            s1_bad   <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            s1_addr  <= cfg.bad ? '0 : perm_addr;
            s1_blog  <= cfg.byte_log;
            s1_bad   <= cfg.bad;
        end
    end

    swz_bank_split #(.AW(AW), .NUM_BANKS(NB), .WORD_BYTES(WORD_BYTES)) u_split (
        .addr     (s1_addr),
        .byte_log (s1_blog),
        .bank     (sp_bank),
        .line     (sp_line)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_bank  <= '0;
            out_line  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            out_addr  <= s1_bad ? '0 : s1_addr;
            out_bank  <= s1_bad ? '0 : sp_bank;
            out_line  <= s1_bad ? '0 : sp_line;
            out_err   <= s1_bad;
        end
    end

    // R2: valid travels through both stages
    p_stage1_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1_valid);
    p_stage2_follow_r2: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);
    p_idle_follow_r2: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> !out_valid);

    // R3: kept low bits unchanged by the permutation
    p_low_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_bad) |->
        (((s1_addr ^ $past(in_addr)) & ((AW'(1) << $past(cfg.keep)) - AW'(1))) == '0));

    // R4: only the fold field may differ
    p_fold_region_r4: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_bad) |->
        ((((s1_addr ^ $past(in_addr)) >> $past(cfg.keep)) >> $past(cfg.fold)) == '0));

    // R5: no swizzle means no change
    p_none_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_bad && $past(in_mode) == 2'd0) |-> (s1_addr == $past(in_addr)));

    // R6: for 4-byte elements bank word equals the element address
    p_word_elem_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_err && $past(s1_blog) == 2'd2) |-> ({out_line, out_bank} == out_addr));

    // R7: error result is all zero
    p_err_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err) |-> (out_addr == '0 && out_bank == '0 && out_line == '0));
endmodule

// File: tb/tb_swz_bank_mapper.sv
module tb_swz_bank_mapper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [19:0] in_addr = '0;
    logic [1:0]  in_width = '0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic [19:0] out_addr;
    logic [4:0]  out_bank;
    logic [14:0] out_line;
    logic        out_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    swz_bank_mapper dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .in_width(in_width), .in_mode(in_mode), .out_valid(out_valid),
        .out_addr(out_addr), .out_bank(out_bank), .out_line(out_line),
        .out_err(out_err)
    );

    localparam int NV = 8;
    // width, mode, address, expected address, bank, line, err
    localparam logic [1:0]  TW[NV] = '{2'd1, 2'd0, 2'd2, 2'd1, 2'd3, 2'd1, 2'd0, 2'd2};
    localparam logic [1:0]  TM[NV] = '{2'd3, 2'd1, 2'd2, 2'd0, 2'd3, 2'd3, 2'd3, 2'd3};
    localparam logic [19:0] TA[NV] = '{20'd64, 20'd384, 20'd165, 20'h12345,
                                       20'hFFFFF, 20'hFFFFF, 20'd112, 20'd224};
    localparam logic [19:0] XA[NV] = '{20'd72, 20'd400, 20'd161, 20'h12345,
                                       20'd0, 20'hFFFC7, 20'd112, 20'd252};
    localparam logic [4:0]  XB[NV] = '{5'd4, 5'd4, 5'd1, 5'd2, 5'd0, 5'd3, 5'd28, 5'd28};
    localparam logic [14:0] XL[NV] = '{15'd1, 15'd3, 15'd5, 15'd1165, 15'd0,
                                       15'd16383, 15'd0, 15'd7};
    localparam logic        XE[NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    // requirement exercised by each row: R4 16b/128B, R4 8b/32B, R3 32b/64B,
    // R5 none, R7 bad width, R6 all-ones, R3 empty fold field, R6 32b/128B
    localparam int          TR[NV] = '{4, 4, 3, 5, 7, 6, 3, 6};

    task automatic chk(input string tag, input logic [19:0] ea, input logic [4:0] eb,
                       input logic [14:0] el, input logic ee);
        checks++;
        if (!(out_valid === 1'b1 && out_addr === ea && out_bank === eb &&
              out_line === el && out_err === ee)) begin
            errors++;
            $display("FAIL %s: got v=%0b addr=%h bank=%0d line=%0d err=%0b, expected v=1 addr=%h bank=%0d line=%0d err=%0b",
                     tag, out_valid, out_addr, out_bank, out_line, out_err, ea, eb, el, ee);
        end
    endtask

    task automatic send(input logic [1:0] w, input logic [1:0] m, input logic [19:0] a);
        in_valid = 1'b1;
        in_width = w;
        in_mode  = m;
        in_addr  = a;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: out_valid=%0b expected 0", out_valid);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 after reset: out_valid=%0b expected 0", out_valid);
        end

        // table walk, one vector at a time (R2 latency of two edges)
        for (int k = 0; k < NV; k++) begin
            send(TW[k], TM[k], TA[k]);
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            chk($sformatf("R%0d vector %0d", TR[k], k), XA[k], XB[k], XL[k], XE[k]);
        end

        // R2: idle input gives no valid result
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2 idle: out_valid=%0b expected 0", out_valid);
        end

        // R8: streamed swizzled column, 16-bit, 128B, results back to back
        for (int k = 0; k < 10; k++) begin
            if (k < 8) send(2'd1, 2'd3, 20'(64 * k));
            else in_valid = 1'b0;
            if (k >= 2)
                chk($sformatf("R8 swizzled column row %0d", k - 2), 20'(72 * (k - 2)),
                    5'(4 * (k - 2)), 15'((36 * (k - 2)) / 32), 1'b0);
            @(negedge clk);
        end
        in_valid = 1'b0;

        // R9: streamed plain column, every row in bank 0
        for (int k = 0; k < 10; k++) begin
            if (k < 8) send(2'd1, 2'd0, 20'(64 * k));
            else in_valid = 1'b0;
            if (k >= 2)
                chk($sformatf("R9 plain column row %0d", k - 2), 20'(64 * (k - 2)),
                    5'd0, 15'(k - 2), 1'b0);
            @(negedge clk);
        end
        in_valid = 1'b0;

        // R7: bad width between good vectors, streamed
        send(2'd2, 2'd3, 20'd224);
        @(negedge clk);
        send(2'd3, 2'd1, 20'd500);
        @(negedge clk);
        send(2'd0, 2'd3, 20'd112);
        chk("R6 before bad width", 20'd252, 5'd28, 15'd7, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 bad width zeroed", 20'd0, 5'd0, 15'd0, 1'b1);
        @(negedge clk);
        chk("R7 error cleared after bad width", 20'd112, 5'd28, 15'd0, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule